// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block keeps the programmable configuration word of a synchronous DRAM controller and turns each burst request into the sequence of column addresses the burst must visit. A load strobe captures the configuration word. It selects the burst length, the beat ordering, the read latency and a write single-beat override. The block decodes that word and reports any reserved encoding on an error output.

A start strobe supplies the first column and whether the burst is a read or a write. From the next cycle on, the block presents one column address per cycle with a valid flag, and raises a last-beat flag on the final beat. Sequential ordering counts upward and wraps inside the aligned block. Interleaved ordering XORs the beat number into the low bits. Full-page bursts run around the whole column space until they are stopped.

A stop input ends any burst early. A new start cuts the running burst short and begins the next one. A suspend input freezes the sequence while it is asserted.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After a synchronous active-low reset, col_valid and col_last are 0, mode_err is 0 and cas_lat is 2. The stored word is 13'h020: length 1, sequential ordering, latency 2.
- R2: When mode_ld is high at a clock edge, mode_word is stored. cas_lat then shows 2 when stored bits 6..4 are 010, shows 3 when they are 011, and shows 0 otherwise.
- R3: mode_err is 1 exactly when any of these holds for the stored word: length code (bits 2..0) is 100, 101 or 110; length code 111 is combined with bit 3 = 1; bits 6..4 are neither 010 nor 011; bits 8..7 are not 00. Bits 12..10 never raise it.
- R4: A start with suspend low and mode_err low gives col_valid = 1 and col_addr = start_col on the next cycle. That cycle is beat 0.
- R5: With bit 3 = 0, beat k keeps the column bits above log2(L) from the start column. The low log2(L) bits are (start + k) mod L. L is 1, 2, 4 or 8 for length codes 000, 001, 010 and 011.
- R6: With bit 3 = 1, beat k presents start_col XOR k.
- R7: col_last is 1 on beat L-1. col_valid is 0 in the following cycle unless a new start was accepted.
- R8: Length code 111 with bit 3 = 0 gives a full-page burst. The address increments modulo 512 (wrapping 511 to 0), and col_last stays 0.
- R9: When bit 9 = 1, a burst started with start_wr = 1 has a single beat, even with length code 111. A burst started with start_wr = 0 keeps the programmed length.
- R10: A stop with suspend low during a valid beat makes col_valid 0 in the next cycle, at every length.
- R11: A start accepted during a running burst replaces it: the next cycle shows beat 0 of the new burst.
- R12: While suspend is high, col_addr, col_valid and col_last hold their values in the next cycle, and start and stop have no effect. A mode load is still captured.
- R13: A start while mode_err is 1 is ignored: an idle block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_ld | input | 1 | Store mode_word at this edge |
| mode_word | input | 13 | Configuration word |
| burst_start | input | 1 | Begin a new burst |
| start_col | input | 9 | First column of the burst |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| burst_stop | input | 1 | End the running burst |
| suspend | input | 1 | Freeze the sequence this cycle |
| col_addr | output | 9 | Current column address |
| col_valid | output | 1 | col_addr carries a beat |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Decoded read latency (2, 3, or 0 if reserved) |
| mode_err | output | 1 | Stored word holds a reserved encoding |

## Verification
The bench builds the block with its default 9-bit column and 13-bit configuration word. Each full-page wrap from 511 back to 0 is therefore reached by starting a few columns below the top, and the complete length and ordering space fits in a short run. The reset value of the configuration word is left at its default, so the latency-2, single-beat state is visible right after reset. The random phase mixes legal and reserved words, so the error path and the ignored starts it causes are exercised alongside normal bursts.

// File: rtl/colgen_pkg.sv
// Package: shared field positions and length codes for the column generator.
// Assumes a configuration word of at least 10 bits.
package colgen_pkg;
    localparam int LEN_LSB   = 0;
    localparam int ORDER_BIT = 3;
    localparam int LAT_LSB   = 4;
    localparam int OPM_LSB   = 7;
    localparam int WSGL_BIT  = 9;

    typedef enum logic [2:0] {
        BLEN_1    = 3'b000,
        BLEN_2    = 3'b001,
        BLEN_4    = 3'b010,
        BLEN_8    = 3'b011,
        BLEN_PAGE = 3'b111
    } blen_e;

    typedef enum logic [2:0] {
        LAT_2 = 3'b010,
        LAT_3 = 3'b011
    } lat_e;
endpackage

// File: rtl/colgen_mode_reg.sv
// Module: colgen_mode_reg
// Holds the configuration word, decodes its fields and flags reserved codes.
// Assumes MODE_W >= 10. Reserved upper bits are stored but never checked.
module colgen_mode_reg
    import colgen_pkg::*;
#(
    parameter int                  MODE_W   = 13,
    parameter logic [MODE_W-1:0]   RST_WORD = 13'h020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [MODE_W-1:0] word_in,
    output logic [2:0]        len_code,
    output logic              inter,
    output logic              wr_single,
    output logic [1:0]        cas_lat,
    output logic              err
);
    logic [MODE_W-1:0] word_q;
    logic [2:0]        lat_code;
    logic              len_bad;
    logic              lat_bad;

    // Capture the configuration word on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  word_q <= RST_WORD;
        else if (ld) word_q <= word_in;
    end

    assign len_code  = word_q[LEN_LSB +: 3];
    assign inter     = word_q[ORDER_BIT];
    assign wr_single = word_q[WSGL_BIT];
    assign lat_code  = word_q[LAT_LSB +: 3];

    // Decode the length field and find reserved length codes.
    always_comb begin
        unique case (len_code)
            BLEN_1, BLEN_2, BLEN_4, BLEN_8: len_bad = 1'b0;
            BLEN_PAGE:                      len_bad = inter;
            default:                        len_bad = 1'b1;
        endcase
    end

    // Decode the latency field into a cycle count (0 when reserved).
    always_comb begin
        unique case (lat_code)
            LAT_2:   begin cas_lat = 2'd2; lat_bad = 1'b0; end
            LAT_3:   begin cas_lat = 2'd3; lat_bad = 1'b0; end
            default: begin cas_lat = 2'd0; lat_bad = 1'b1; end
        endcase
    end

    assign err = len_bad | lat_bad | (|word_q[OPM_LSB +: 2]);
endmodule

// File: rtl/colgen_seq.sv
// Module: colgen_seq
// Walks the beats of one burst and forms each column address.
// Assumes COL_W >= 3. The caller must not start a burst while err is high.
module colgen_seq
    import colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             wr,
    input  logic             stop,
    input  logic             suspend,
    input  logic [2:0]       len_code,
    input  logic             inter,
    input  logic             wr_single,
    input  logic             err,
    output logic [COL_W-1:0] col,
    output logic             vld,
    output logic             last
);
    logic             act;
    logic             full_q;
    logic             inter_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] mask_q;
    logic [COL_W-1:0] mask_d;
    logic             full_d;

    // Turn the length code into a wrap mask and a full-page flag.
    always_comb begin
        full_d = 1'b0;
        unique case (len_code)
            BLEN_2:    mask_d = COL_W'(1);
            BLEN_4:    mask_d = COL_W'(3);
            BLEN_8:    mask_d = COL_W'(7);
            BLEN_PAGE: begin mask_d = '1; full_d = 1'b1; end
            default:   mask_d = '0;
        endcase
    end

    assign last = act && !full_q && (beat_q == mask_q);

    // Burst state: start, advance, finish; everything holds under suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= 1'b0;
            full_q  <= 1'b0;
            inter_q <= 1'b0;
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
        end else if (!suspend) begin
            if (start && !err) begin
                act     <= 1'b1;
                base_q  <= start_col;
                beat_q  <= '0;
                inter_q <= inter;
                if (wr && wr_single) begin
                    mask_q <= '0;
                    full_q <= 1'b0;
                end else begin
                    mask_q <= mask_d;
                    full_q <= full_d;
                end
            end else if (act) begin
                if (stop || last) act <= 1'b0;
                else              beat_q <= beat_q + 1'b1;
            end
        end
    end

    // Form the address from the start column and the beat number.
    always_comb begin
        if (inter_q) col = base_q ^ beat_q;
        else         col = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
    end

    assign vld = act;
endmodule

// File: rtl/sdram_burst_colgen.sv
// Module: sdram_burst_colgen
// Top of the burst column generator: configuration register plus beat walker.
// Assumes the default widths of a 9-bit column and a 13-bit configuration word.
module sdram_burst_colgen #(
    parameter int                  COL_W    = 9,
    parameter int                  MODE_W   = 13,
    parameter logic [MODE_W-1:0]   RST_WORD = 13'h020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_ld,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              burst_start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_wr,
    input  logic              burst_stop,
    input  logic              suspend,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        cas_lat,
    output logic              mode_err
);
    logic [2:0] len_code;
    logic       inter;
    logic       wr_single;

    colgen_mode_reg #(.MODE_W(MODE_W), .RST_WORD(RST_WORD)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (mode_ld),
        .word_in   (mode_word),
        .len_code  (len_code),
        .inter     (inter),
        .wr_single (wr_single),
        .cas_lat   (cas_lat),
        .err       (mode_err)
    );

    colgen_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (burst_start),
        .start_col (start_col),
        .wr        (start_wr),
        .stop      (burst_stop),
        .suspend   (suspend),
        .len_code  (len_code),
        .inter     (inter),
        .wr_single (wr_single),
        .err       (mode_err),
        .col       (col_addr),
        .vld       (col_valid),
        .last      (col_last)
    );
endmodule

// File: rtl/colgen_chk.sv
// Module: colgen_chk
// Protocol checks on the generator ports, attached to the top with bind.
module colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             burst_start,
    input logic [COL_W-1:0] start_col,
    input logic             burst_stop,
    input logic             suspend,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last,
    input logic             mode_err
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start && !suspend && !mode_err |=> col_valid && col_addr == $past(start_col)); // R4

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        col_last && !suspend && !burst_start |=> !col_valid); // R7

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid && burst_stop && !suspend && !burst_start |=> !col_valid); // R10

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> $stable(col_valid) && $stable(col_addr) && $stable(col_last)); // R12

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid && mode_err && !suspend |=> !col_valid); // R13

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R7
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .start_col   (start_col),
    .burst_stop  (burst_stop),
    .suspend     (suspend),
    .col_addr    (col_addr),
    .col_valid   (col_valid),
    .col_last    (col_last),
    .mode_err    (mode_err)
);

// File: tb/sdram_burst_colgen_tb.sv
// Bench: directed corners plus seeded random traffic against a bench-side model.
module sdram_burst_colgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_ld = 1'b0;
    logic [12:0] mode_word = '0;
    logic        burst_start = 1'b0;
    logic [8:0]  start_col = '0;
    logic        start_wr = 1'b0;
    logic        burst_stop = 1'b0;
    logic        suspend = 1'b0;
    logic [8:0]  col_addr;
    logic        col_valid;
    logic        col_last;
    logic [1:0]  cas_lat;
    logic        mode_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model state
    logic [12:0] m_mode;
    bit          m_act;
    logic [8:0]  m_base;
    int          m_k;
    int          m_len;
    bit          m_full;
    bit          m_inter;
    string       cur_tag = "R1";

    always #10 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_word(mode_word),
        .burst_start(burst_start), .start_col(start_col), .start_wr(start_wr),
        .burst_stop(burst_stop), .suspend(suspend), .col_addr(col_addr),
        .col_valid(col_valid), .col_last(col_last), .cas_lat(cas_lat),
        .mode_err(mode_err)
    );

    function automatic bit f_err(input logic [12:0] w);
        bit b = 0;
        if (w[2:0] inside {3'd4, 3'd5, 3'd6}) b = 1;
        if (w[2:0] == 3'd7 && w[3]) b = 1;
        if (!(w[6:4] inside {3'd2, 3'd3})) b = 1;
        if (w[8:7] != 2'b00) b = 1;
        return b;
    endfunction

    function automatic int f_lat(input logic [12:0] w);
        if (w[6:4] == 3'd2) return 2;
        if (w[6:4] == 3'd3) return 3;
        return 0;
    endfunction

    function automatic int f_len(input logic [12:0] w, input bit wr);
        if (wr && w[9]) return 1;
        case (w[2:0])
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic logic [8:0] f_col(input logic [8:0] b, input int k, input int len, input bit inter);
        int off;
        if (inter) return b ^ 9'(k);
        off = int'(b) % len;
        return 9'(int'(b) - off + (off + k) % len);
    endfunction

    task automatic ck(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_tag, what, act, exp);
        end
    endtask

    // Compare all outputs with the model (called between edges).
    task automatic check_outputs();
        bit exp_last = m_act && !m_full && (m_k == m_len - 1);
        ck("col_valid", int'(col_valid), int'(m_act));
        ck("col_last", int'(col_last), int'(exp_last));
        ck("mode_err", int'(mode_err), int'(f_err(m_mode)));
        ck("cas_lat", int'(cas_lat), f_lat(m_mode));
        if (m_act) ck("col_addr", int'(col_addr), int'(f_col(m_base, m_k, m_len, m_inter)));
    endtask

    // Advance the model by one edge using the inputs now driven.
    task automatic model_edge();
        bit last = m_act && !m_full && (m_k == m_len - 1);
        bit err = f_err(m_mode);
        if (!suspend) begin
            if (burst_start && !err) begin
                m_act = 1; m_base = start_col; m_k = 0;
                m_len = f_len(m_mode, start_wr);
                m_full = (m_len == 512);
                m_inter = m_mode[3];
            end else if (m_act) begin
                if (burst_stop || last) m_act = 0;
                else m_k = (m_k + 1) % 512;
            end
        end
        if (mode_ld) m_mode = mode_word;
    endtask

    // One cycle: check the previous result, drive new inputs, update the model.
    task automatic cyc(input bit ld, input logic [12:0] w, input bit st, input logic [8:0] c,
                       input bit wr, input bit stp, input bit sus, input string tag);
        @(negedge clk);
        check_outputs();
        cur_tag = tag;
        mode_ld = ld; mode_word = w; burst_start = st; start_col = c;
        start_wr = wr; burst_stop = stp; suspend = sus;
        model_edge();
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 13'h0, 0, 9'h0, 0, 0, 0, tag);
    endtask

    task automatic load(input logic [12:0] w, input string tag);
        cyc(1, w, 0, 9'h0, 0, 0, 0, tag);
    endtask

    task automatic go(input logic [8:0] c, input bit wr, input string tag);
        cyc(0, 13'h0, 1, c, wr, 0, 0, tag);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_mode = 13'h020; m_act = 0; m_base = 0; m_k = 0; m_len = 1; m_full = 0; m_inter = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R2: latency decode
        load(13'h030, "R2"); idle(1, "R2");
        load(13'h050, "R2"); idle(1, "R3");
        // R3: reserved codes
        load(13'h024, "R3"); idle(1, "R3");
        load(13'h02F, "R3"); idle(1, "R3");
        load(13'h0A0, "R3"); idle(1, "R3");
        load(13'h1C20, "R3"); idle(1, "R3");
        // R13: start ignored under error
        load(13'h024, "R13"); go(9'h10, 0, "R13"); idle(3, "R13");

        // R4/R5: sequential lengths
        load(13'h021, "R5"); go(9'h0B, 0, "R4"); idle(3, "R5");
        load(13'h022, "R5"); go(9'h0E, 0, "R5"); idle(5, "R7");
        load(13'h033, "R5"); go(9'h1FD, 1, "R5"); idle(10, "R7");
        // R6: interleaved
        load(13'h02B, "R6"); go(9'h15, 0, "R6"); idle(10, "R6");
        load(13'h02A, "R6"); go(9'h03, 1, "R6"); idle(6, "R6");
        // R8: full page wrap
        load(13'h027, "R8"); go(9'h1FD, 0, "R8"); idle(6, "R8");
        cyc(0, 13'h0, 0, 9'h0, 0, 1, 0, "R10"); idle(2, "R10");
        // R9: write single beat, read full length
        load(13'h223, "R9"); go(9'h44, 1, "R9"); idle(3, "R9");
        go(9'h44, 0, "R9"); idle(10, "R9");
        load(13'h227, "R9"); go(9'h80, 1, "R9"); idle(3, "R9");
        // R10: stop at length 8 and 2
        load(13'h023, "R10"); go(9'h20, 0, "R10"); idle(2, "R10");
        cyc(0, 13'h0, 0, 9'h0, 0, 1, 0, "R10"); idle(2, "R10");
        load(13'h021, "R10"); go(9'h20, 0, "R10");
        cyc(0, 13'h0, 0, 9'h0, 0, 1, 0, "R10"); idle(2, "R10");
        // R11: restart mid burst
        load(13'h023, "R11"); go(9'h30, 0, "R11"); idle(2, "R11");
        go(9'h155, 0, "R11"); idle(10, "R11");
        // R12: suspend holds, start/stop ignored, load still taken
        go(9'h60, 0, "R12"); idle(1, "R12");
        cyc(0, 13'h0, 1, 9'h1AA, 0, 1, 1, "R12");
        cyc(1, 13'h032, 0, 9'h0, 0, 1, 1, "R12");
        idle(10, "R12");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit ld = ($urandom % 40) == 0;
            logic [12:0] w;
            int pick = $urandom % 6;
            w = 13'($urandom);
            if (pick != 0) begin
                logic [2:0] lc;
                case ($urandom % 5)
                    0: lc = 3'd0; 1: lc = 3'd1; 2: lc = 3'd2; 3: lc = 3'd3; default: lc = 3'd7;
                endcase
                w = {3'b000, 1'($urandom), 2'b00, 3'(2 + $urandom % 2),
                     (lc == 3'd7) ? 1'b0 : 1'($urandom), lc};
            end
            cyc(ld, w, ($urandom % 7) == 0, 9'($urandom), 1'($urandom),
                ($urandom % 20) == 0, ($urandom % 10) == 0, "R11");
        end
        @(negedge clk);
        check_outputs();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule